// File: doc/BRIEF.md
# Write-Only Serial Control Register Target for a Video Preamplifier

This block is a two-wire serial bus target that only accepts writes. It runs on a fast system clock and samples the bus clock (SCL) and data (SDA) lines. It detects START and STOP conditions and matches one fixed device address byte. After the address it takes a register-pointer byte, then stores every following data byte into a small bank of 8-bit control registers. The pointer advances after each data byte, so one transaction can update several neighbouring registers.

The register bank drives the analog front end directly:

| Pointer | Register | Stored bits |
|---------|----------|-------------|
| 0x00 | contrast | all 8 |
| 0x01 | brightness | all 8 |
| 0x02 | channel 1 drive gain | all 8 |
| 0x03 | channel 2 drive gain | all 8 |
| 0x04 | channel 3 drive gain | all 8 |
| 0x05 | on-screen-display level | all 8 |
| 0x06 | output DC level | low 4 |
| 0x07 | mode | clamp sync source, clamp width, semi-transparent overlay, blanking polarity |

Read requests and foreign addresses are refused. The target pulls SDA low only during acknowledge slots.

Top module: `pxctl_wr_target`

## Requirements
- R1: After a synchronous active-low reset, every register output is zero and `sda_pull_o` is 0. Mode bit 7 at 0 selects positive blanking polarity.
- R2: An address byte equal to 0xDC (device address plus write bit 0) is acknowledged. `sda_pull_o` is 1 while SCL is high in the 9th clock of that byte, and it is released only while SCL is low.
- R3: An address byte of 0xDD (read form) or any other value is not acknowledged. All bus traffic up to the next START then leaves every register output unchanged and `sda_pull_o` at 0.
- R4: Bytes are taken MSB first. After an acknowledged address, the next byte sets the register pointer and is acknowledged. Each later data byte is acknowledged and written to the register the pointer selects:
  - 0x00 contrast
  - 0x01 brightness
  - 0x02, 0x03, 0x04 drive gains for channels 1, 2, 3
  - 0x05 on-screen-display level
  - 0x06 output DC level
  - 0x07 mode
- R5: The pointer advances by one after every data byte. It is 8 bits wide and wraps from 0xFF to 0x00.
- R6: A data byte sent while the pointer is in 0x08..0xFF is still acknowledged. Its value is discarded and all register outputs keep their values.
- R7: A STOP or a repeated START cancels the pointer. After the next START, the byte that follows an acknowledged address is again taken as a pointer, not as data.
- R8: Only the stored bits of each register reach the outputs:
  - The DC level keeps data bits 3:0.
  - Mode bit 0 drives `clamp_on_blank_o`.
  - Mode bits 2:1 drive `clamp_width_o`.
  - Mode bit 6 drives `semi_osd_o`.
  - Mode bit 7 drives `blank_neg_o`.
  - Mode bits 5:3 are dropped.
- R9: `sda_pull_o` is 0 while SCL is high during any of the eight data bits of a byte.
- R10: A pulse of two system clocks or less on SCL or SDA has no effect. This covers an SCL pulse while SCL is low and an SDA pulse while SCL is high.
- R11: When SDA changes in the same system clock as an SCL rising or falling edge (zero setup or hold), the change is read as data. It is never read as a START or STOP condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls the open-drain data line low |
| contrast_o | output | 8 | Contrast gain code |
| brightness_o | output | 8 | Brightness offset code |
| gain_ch1_o | output | 8 | Channel 1 drive gain |
| gain_ch2_o | output | 8 | Channel 2 drive gain |
| gain_ch3_o | output | 8 | Channel 3 drive gain |
| osd_level_o | output | 8 | On-screen-display level |
| dc_level_o | output | 4 | Output DC level step |
| clamp_on_blank_o | output | 1 | 1: clamp pulse follows the blanking input, 0: follows horizontal sync |
| clamp_width_o | output | 2 | Clamp pulse width select |
| semi_osd_o | output | 1 | Semi-transparent overlay enable |
| blank_neg_o | output | 1 | 1: negative blanking input polarity |

## Verification
Two detectors can act in the same system clock: the SCL edge detector that shifts in a bit, and the START/STOP detector that watches SDA while SCL is high. The bench runs whole transactions in a zero-margin mode. In that mode SDA changes in the very clock in which SCL rises or falls, so both filtered lines move together. A per-clock reference model then judges the result: a spurious condition would show up as a missing acknowledge or a wrong register value. A second pass places two-clock pulses on SCL during its low phase and on SDA during its high phase. That pass checks that the glitch filter stops either detector from firing.

// File: rtl/pxctl_pkg.sv
// Shared constants and types for the write-only control register target.
// Assumes 8-bit registers and a single fixed device address byte.
package pxctl_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned NREG      = 8;
    localparam int unsigned DC_W      = 4;
    localparam logic [7:0]  DEV_WR_ADDR = 8'hDC;

    localparam int unsigned IDX_CONTRAST = 0;
    localparam int unsigned IDX_BRIGHT   = 1;
    localparam int unsigned IDX_GAIN1    = 2;
    localparam int unsigned IDX_GAIN2    = 3;
    localparam int unsigned IDX_GAIN3    = 4;
    localparam int unsigned IDX_OSD      = 5;
    localparam int unsigned IDX_DC       = 6;
    localparam int unsigned IDX_MODE     = 7;

    // Bits kept by each register; the rest are stored as zero.
    function automatic logic [7:0] keep_mask(input int unsigned idx);
        case (idx)
            IDX_DC:   return 8'h0F;
            IDX_MODE: return 8'hC7;
            default:  return 8'hFF;
        endcase
    endfunction

    typedef enum logic [1:0] {PH_IDLE, PH_SHIFT, PH_ACK, PH_SKIP} phase_t;
    typedef enum logic [1:0] {BK_ADDR, BK_PTR, BK_DATA} kind_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

endpackage

// File: rtl/pxctl_deglitch.sv
// Brings one bus line into the clock domain and suppresses short pulses.
// A new level is accepted only after VOTE_LEN identical synchronized samples.
// Assumes SYNC_STAGES >= 2 and VOTE_LEN >= 2; lines idle at RESET_VAL.
module pxctl_deglitch #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned VOTE_LEN    = 3,
    parameter logic        RESET_VAL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_LEN-1:0]    hist_q;

    // Purpose: metastability chain followed by the sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{RESET_VAL}};
            hist_q <= {VOTE_LEN{RESET_VAL}};
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            hist_q <= {hist_q[VOTE_LEN-2:0], sync_q[SYNC_STAGES-1]};
        end
    end

    // Purpose: change the clean level only on a unanimous history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_o <= RESET_VAL;
        end else if (&hist_q) begin
            clean_o <= 1'b1;
        end else if (~|hist_q) begin
            clean_o <= 1'b0;
        end
    end

endmodule

// File: rtl/pxctl_bus_events.sv
// Turns the filtered SCL/SDA levels into one-cycle bus events.
// START/STOP need SCL high in this and the previous cycle, so an SDA move
// in the same cycle as an SCL edge counts as data, never as a condition.
module pxctl_bus_events
    import pxctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    logic scl_q;
    logic sda_q;

    // Purpose: remember the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Purpose: decode edges and bus conditions.
    always_comb begin
        evt_o.start = scl_i & scl_q & sda_q & ~sda_i;
        evt_o.stop  = scl_i & scl_q & ~sda_q & sda_i;
        evt_o.rise  = scl_i & ~scl_q;
        evt_o.fall  = ~scl_i & scl_q;
    end

endmodule

// File: rtl/pxctl_wr_engine.sv
// Byte engine for write-only transfers: address match, pointer load,
// data write strobes with pointer advance, and acknowledge slot control.
// A byte is complete on the 8th SCL rise, and any write is issued then.
// The acknowledge pull starts on the following SCL fall and ends on the next fall.
module pxctl_wr_engine
    import pxctl_pkg::*;
#(
    parameter int unsigned W  = BYTE_W,
    parameter logic [W-1:0] DEV_ADDR = DEV_WR_ADDR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  bus_evt_t     evt_i,
    input  logic         sda_i,
    output logic         pull_o,
    output logic         wr_en_o,
    output logic [W-1:0] wr_addr_o,
    output logic [W-1:0] wr_data_o,
    output logic [W-1:0] ptr_o
);
    localparam int unsigned CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(W);

    phase_t           phase_q;
    kind_t            kind_q;
    logic [CNT_W-1:0] bitcnt_q;
    logic [W-1:0]     shreg_q;
    logic             ack_pend_q;
    logic [W-1:0]     byte_next;

    // Purpose: the byte including the bit sampled this cycle.
    always_comb begin
        byte_next = {shreg_q[W-2:0], sda_i};
    end

    // Purpose: transfer state machine with condition priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            kind_q     <= BK_ADDR;
            bitcnt_q   <= '0;
            shreg_q    <= '0;
            ack_pend_q <= 1'b0;
            pull_o     <= 1'b0;
            wr_en_o    <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
            ptr_o      <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (evt_i.start) begin
                phase_q    <= PH_SHIFT;
                kind_q     <= BK_ADDR;
                bitcnt_q   <= '0;
                ack_pend_q <= 1'b0;
                pull_o     <= 1'b0;
            end else if (evt_i.stop) begin
                phase_q    <= PH_IDLE;
                ack_pend_q <= 1'b0;
                pull_o     <= 1'b0;
            end else begin
                unique case (phase_q)
                    PH_SHIFT: begin
                        if (evt_i.rise && bitcnt_q < ALL_BITS) begin
                            shreg_q  <= byte_next;
                            bitcnt_q <= bitcnt_q + 1'b1;
                            if (bitcnt_q == LAST_BIT) begin
                                unique case (kind_q)
                                    BK_ADDR: ack_pend_q <= (byte_next == DEV_ADDR);
                                    BK_PTR: begin
                                        ack_pend_q <= 1'b1;
                                        ptr_o      <= byte_next;
                                    end
                                    default: begin
                                        ack_pend_q <= 1'b1;
                                        wr_en_o    <= 1'b1;
                                        wr_addr_o  <= ptr_o;
                                        wr_data_o  <= byte_next;
                                        ptr_o      <= ptr_o + 1'b1;
                                    end
                                endcase
                            end
                        end else if (evt_i.fall && bitcnt_q == ALL_BITS) begin
                            if (ack_pend_q) begin
                                pull_o  <= 1'b1;
                                phase_q <= PH_ACK;
                            end else begin
                                phase_q <= PH_SKIP;
                            end
                        end
                    end
                    PH_ACK: begin
                        if (evt_i.fall) begin
                            pull_o     <= 1'b0;
                            phase_q    <= PH_SHIFT;
                            bitcnt_q   <= '0;
                            ack_pend_q <= 1'b0;
                            kind_q     <= (kind_q == BK_ADDR) ? BK_PTR : BK_DATA;
                        end
                    end
                    default: begin
                        pull_o <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pxctl_reg_bank.sv
// Flat control register bank. One write port; only the bits named by
// keep_mask are stored. Pointers at or above NREG write nothing.
module pxctl_reg_bank
    import pxctl_pkg::*;
#(
    parameter int unsigned N  = NREG,
    parameter int unsigned W  = BYTE_W,
    parameter int unsigned AW = BYTE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en_i,
    input  logic [AW-1:0]  wr_addr_i,
    input  logic [W-1:0]   wr_data_i,
    output logic [N*W-1:0] bank_o
);
    for (genvar g = 0; g < N; g++) begin : g_reg
        localparam logic [W-1:0] KEEP = W'(keep_mask(g));
        logic [W-1:0] val_q;

        // Purpose: load this register when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_en_i && wr_addr_i == AW'(g)) begin
                val_q <= wr_data_i & KEEP;
            end
        end

        assign bank_o[g*W +: W] = val_q;
    end

endmodule

// File: rtl/pxctl_wr_target.sv
// Top of the write-only control register target. It filters SCL/SDA,
// decodes bus events, runs the byte engine and fans the bank out to
// named control outputs. Assumes an external pull-up on SDA.
module pxctl_wr_target
    import pxctl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned VOTE_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [BYTE_W-1:0] contrast_o,
    output logic [BYTE_W-1:0] brightness_o,
    output logic [BYTE_W-1:0] gain_ch1_o,
    output logic [BYTE_W-1:0] gain_ch2_o,
    output logic [BYTE_W-1:0] gain_ch3_o,
    output logic [BYTE_W-1:0] osd_level_o,
    output logic [DC_W-1:0]   dc_level_o,
    output logic              clamp_on_blank_o,
    output logic [1:0]        clamp_width_o,
    output logic              semi_osd_o,
    output logic              blank_neg_o
);
    localparam int unsigned BANK_W = NREG * BYTE_W;

    logic              scl_clean;
    logic              sda_clean;
    bus_evt_t          evt;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] wr_ptr;
    logic [BANK_W-1:0] bank_flat;
    logic [BYTE_W-1:0] mode_r;

    pxctl_deglitch #(.SYNC_STAGES(SYNC_STAGES), .VOTE_LEN(VOTE_LEN), .RESET_VAL(1'b1)) u_scl_flt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .clean_o(scl_clean)
    );

    pxctl_deglitch #(.SYNC_STAGES(SYNC_STAGES), .VOTE_LEN(VOTE_LEN), .RESET_VAL(1'b1)) u_sda_flt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .clean_o(sda_clean)
    );

    pxctl_bus_events u_evt (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_clean), .sda_i(sda_clean), .evt_o(evt)
    );

    pxctl_wr_engine #(.W(BYTE_W), .DEV_ADDR(DEV_WR_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .sda_i(sda_clean),
        .pull_o(sda_pull_o), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data), .ptr_o(wr_ptr)
    );

    pxctl_reg_bank #(.N(NREG), .W(BYTE_W), .AW(BYTE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .bank_o(bank_flat)
    );

    // Purpose: name each register slice for the analog controls.
    always_comb begin
        contrast_o       = bank_flat[IDX_CONTRAST*BYTE_W +: BYTE_W];
        brightness_o     = bank_flat[IDX_BRIGHT*BYTE_W +: BYTE_W];
        gain_ch1_o       = bank_flat[IDX_GAIN1*BYTE_W +: BYTE_W];
        gain_ch2_o       = bank_flat[IDX_GAIN2*BYTE_W +: BYTE_W];
        gain_ch3_o       = bank_flat[IDX_GAIN3*BYTE_W +: BYTE_W];
        osd_level_o      = bank_flat[IDX_OSD*BYTE_W +: BYTE_W];
        dc_level_o       = bank_flat[IDX_DC*BYTE_W +: DC_W];
        mode_r           = bank_flat[IDX_MODE*BYTE_W +: BYTE_W];
        clamp_on_blank_o = mode_r[0];
        clamp_width_o    = mode_r[2:1];
        semi_osd_o       = mode_r[6];
        blank_neg_o      = mode_r[7];
    end

endmodule

// File: rtl/pxctl_wr_target_chk.sv
// Property checker for pxctl_wr_target, attached by bind below.
// Observes the filtered SCL, the data pull, the write port and the bank.
module pxctl_wr_target_chk
    import pxctl_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     scl_f,
    input logic                     sda_pull,
    input logic                     wr_en,
    input logic [BYTE_W-1:0]        wr_addr,
    input logic [BYTE_W-1:0]        wr_data,
    input logic [BYTE_W-1:0]        ptr,
    input logic [BYTE_W-1:0]        contrast,
    input logic [NREG*BYTE_W-1:0]   bank
);
    // R9: the pull never moves while SCL stays high.
    p_pull_steady_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f)) |-> $stable(sda_pull));

    // R2: the acknowledge pull is released only while SCL is low.
    p_release_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> !scl_f);

    // R3: without a write strobe the bank holds.
    p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank));

    // R4: a strobe at pointer 0 lands in contrast.
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> contrast == $past(wr_data));

    // R5: the pointer is one past the address just written.
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ptr == wr_addr + 8'd1);

    // R6: writes above the bank change nothing.
    p_unimpl_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= 8'(NREG)) |=> $stable(bank));

endmodule

bind pxctl_wr_target pxctl_wr_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_clean), .sda_pull(sda_pull_o),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ptr(wr_ptr),
    .contrast(contrast_o), .bank(bank_flat)
);

// File: tb/tb_pxctl_wr_target.sv
// Bit-banged bus master with a behavioural reference model compared every clock.
module tb_pxctl_wr_target;
    localparam int HALF = 24;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_pull_o;
    logic [7:0] contrast_o, brightness_o, gain_ch1_o, gain_ch2_o, gain_ch3_o, osd_level_o;
    logic [3:0] dc_level_o;
    logic clamp_on_blank_o, semi_osd_o, blank_neg_o;
    logic [1:0] clamp_width_o;

    always #4 clk = ~clk;
    assign sda_bus = sda_m & ~sda_pull_o;

    pxctl_wr_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_pull_o(sda_pull_o),
        .contrast_o(contrast_o), .brightness_o(brightness_o), .gain_ch1_o(gain_ch1_o),
        .gain_ch2_o(gain_ch2_o), .gain_ch3_o(gain_ch3_o), .osd_level_o(osd_level_o),
        .dc_level_o(dc_level_o), .clamp_on_blank_o(clamp_on_blank_o),
        .clamp_width_o(clamp_width_o), .semi_osd_o(semi_osd_o), .blank_neg_o(blank_neg_o)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference model: phase 0 idle, 1 address, 2 pointer, 3 data, 4 ignore.
    logic [7:0] exp_r [8];
    int mph = 0;
    int mptr = 0;
    bit cmp_en = 0;
    bit mis_seen = 0;
    logic [56:0] mis_act, mis_exp;

    function automatic logic [7:0] model_mask(int idx);
        if (idx == 6) return 8'h0F;
        if (idx == 7) return 8'hC7;
        return 8'hFF;
    endfunction

    function automatic logic [56:0] pack_exp();
        return {exp_r[0], exp_r[1], exp_r[2], exp_r[3], exp_r[4], exp_r[5], exp_r[6][3:0],
                exp_r[7][0], exp_r[7][2:1], exp_r[7][6], exp_r[7][7]};
    endfunction

    function automatic logic [56:0] pack_act();
        return {contrast_o, brightness_o, gain_ch1_o, gain_ch2_o, gain_ch3_o, osd_level_o,
                dc_level_o, clamp_on_blank_o, clamp_width_o, semi_osd_o, blank_neg_o};
    endfunction

    // Per-clock comparison of all register outputs against the model.
    always @(negedge clk) begin
        if (cmp_en && pack_act() !== pack_exp()) begin
            if (!mis_seen) begin
                mis_act = pack_act();
                mis_exp = pack_exp();
            end
            mis_seen = 1;
        end
    end

    // Watchdog: a hung run becomes a failed check.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic clk_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic checkpoint(input string tag);
        checks++;
        if (pack_act() !== pack_exp() && !mis_seen) begin
            mis_seen = 1;
            mis_act = pack_act();
            mis_exp = pack_exp();
        end
        if (mis_seen) begin
            fails++;
            $display("FAIL %s registers: actual=%0h expected=%0h", tag, mis_act, mis_exp);
        end
        mis_seen = 0;
    endtask

    task automatic bus_start();
        clk_n(4);
        sda_m = 1'b1;
        clk_n(HALF);
        scl_m = 1'b1;
        clk_n(HALF);
        sda_m = 1'b0;
        clk_n(HALF);
        scl_m = 1'b0;
        mph = 1;
    endtask

    task automatic bus_stop(input string tag);
        clk_n(4);
        sda_m = 1'b0;
        clk_n(HALF);
        scl_m = 1'b1;
        clk_n(HALF);
        sda_m = 1'b1;
        clk_n(HALF);
        mph = 0;
        checkpoint(tag);
    endtask

    // One byte plus acknowledge slot. tight: SDA moves with SCL edges.
    // glitch: 2-clock pulses on SCL (low phase) and SDA (high phase).
    task automatic send_byte(input logic [7:0] b, input bit tight, input bit glitch);
        bit exp_ack;
        string tag;
        int nph, nptr, widx;
        nph = mph; nptr = mptr; widx = -1;
        case (mph)
            1: begin exp_ack = (b == 8'hDC); tag = exp_ack ? "R2" : "R3"; nph = exp_ack ? 2 : 4; end
            2: begin exp_ack = 1; tag = "R4"; nptr = b; nph = 3; end
            3: begin
                exp_ack = 1;
                tag = (mptr < 8) ? "R5" : "R6";
                if (mptr < 8) widx = mptr;
                nptr = (mptr + 1) % 256;
            end
            default: begin exp_ack = 0; tag = "R3"; end
        endcase
        for (int i = 7; i >= 0; i--) begin
            if (!tight) begin
                clk_n(4);
                sda_m = b[i];
            end
            if (glitch) begin
                clk_n(6); scl_m = 1'b1; clk_n(2); scl_m = 1'b0; clk_n(HALF - 8);
            end else begin
                clk_n(HALF);
            end
            if (i == 0) cmp_en = 0;
            scl_m = 1'b1;
            if (tight) sda_m = b[i];
            clk_n(HALF / 2);
            check_eq(tight ? "R11 data-bit pull" : (glitch ? "R10 data-bit pull" : "R9 data-bit pull"),
                     64'(sda_pull_o), 64'd0);
            if (glitch) begin
                sda_m = ~sda_m; clk_n(2); sda_m = ~sda_m; clk_n(HALF / 2 - 2);
            end else begin
                clk_n(HALF / 2);
            end
            scl_m = 1'b0;
            if (tight) sda_m = ~b[i];
        end
        if (!tight) clk_n(4);
        sda_m = 1'b1;
        clk_n(HALF);
        scl_m = 1'b1;
        clk_n(HALF / 2);
        check_eq({tight ? "R11 " : (glitch ? "R10 " : ""), tag, " ack"}, 64'(sda_pull_o), 64'(exp_ack));
        clk_n(HALF / 2);
        scl_m = 1'b0;
        clk_n(4);
        mph = nph;
        mptr = nptr;
        if (widx >= 0) exp_r[widx] = b & model_mask(widx);
        cmp_en = 1;
    endtask

    task automatic model_reset();
        for (int k = 0; k < 8; k++) exp_r[k] = 8'h00;
        mph = 0;
        mptr = 0;
    endtask

    initial begin
        model_reset();
        rst_n = 1'b0;
        clk_n(5);
        rst_n = 1'b1;
        cmp_en = 1;
        clk_n(10);
        // R1: reset state
        checkpoint("R1");
        check_eq("R1 pull", 64'(sda_pull_o), 64'd0);
        check_eq("R1 blank polarity", 64'(blank_neg_o), 64'd0);

        // R2 R4 R5 R8: fill the whole bank in one transfer
        bus_start();
        send_byte(8'hDC, 0, 0);
        send_byte(8'h00, 0, 0);
        send_byte(8'h3C, 0, 0); send_byte(8'h81, 0, 0); send_byte(8'hA5, 0, 0);
        send_byte(8'h5A, 0, 0); send_byte(8'hFF, 0, 0); send_byte(8'h01, 0, 0);
        send_byte(8'h9B, 0, 0); send_byte(8'h79, 0, 0);
        bus_stop("R4");
        check_eq("R8 dc level", 64'(dc_level_o), 64'hB);
        check_eq("R8 mode fields", 64'({blank_neg_o, semi_osd_o, clamp_width_o, clamp_on_blank_o}), 64'b01001);

        // R3: read form and foreign address are refused, data ignored
        bus_start();
        send_byte(8'hDD, 0, 0); send_byte(8'h00, 0, 0); send_byte(8'h11, 0, 0);
        bus_stop("R3");
        bus_start();
        send_byte(8'hDA, 0, 0); send_byte(8'h01, 0, 0); send_byte(8'h22, 0, 0);
        bus_stop("R3");

        // R6 R8: DC level and mode masking, then past the last register
        bus_start();
        send_byte(8'hDC, 0, 0); send_byte(8'h06, 0, 0);
        send_byte(8'hFF, 0, 0); send_byte(8'hFF, 0, 0); send_byte(8'h55, 0, 0);
        bus_stop("R6");
        check_eq("R8 dc level upper dropped", 64'(dc_level_o), 64'hF);
        check_eq("R8 mode all set", 64'({blank_neg_o, semi_osd_o, clamp_width_o, clamp_on_blank_o}), 64'b11111);

        // R5: pointer wraps from 0xFF to 0x00
        bus_start();
        send_byte(8'hDC, 0, 0); send_byte(8'hFE, 0, 0);
        send_byte(8'h11, 0, 0); send_byte(8'h22, 0, 0); send_byte(8'h33, 0, 0);
        bus_stop("R5");
        check_eq("R5 wrap into contrast", 64'(contrast_o), 64'h33);

        // R7: after STOP the first byte is a pointer; repeated START restarts
        bus_start();
        send_byte(8'hDC, 0, 0); send_byte(8'h01, 0, 0); send_byte(8'h77, 0, 0);
        bus_stop("R7");
        bus_start();
        send_byte(8'hDC, 0, 0); send_byte(8'h02, 0, 0); send_byte(8'hAA, 0, 0);
        bus_start();
        send_byte(8'hDC, 0, 0); send_byte(8'h03, 0, 0); send_byte(8'hBB, 0, 0);
        bus_stop("R7");
        check_eq("R7 repeated start pointer", 64'(gain_ch2_o), 64'hBB);

        // R11: zero setup/hold on every bit
        bus_start();
        send_byte(8'hDC, 1, 0); send_byte(8'h03, 1, 0);
        send_byte(8'h5A, 1, 0); send_byte(8'hA5, 1, 0);
        bus_stop("R11");

        // R10: short pulses on both lines
        bus_start();
        send_byte(8'hDC, 0, 1); send_byte(8'h05, 0, 1);
        send_byte(8'hC3, 0, 1); send_byte(8'h0E, 0, 1);
        bus_stop("R10");

        // R1: reset in service clears everything
        cmp_en = 0;
        rst_n = 1'b0;
        model_reset();
        clk_n(3);
        rst_n = 1'b1;
        cmp_en = 1;
        clk_n(10);
        checkpoint("R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule